// File: doc/BRIEF.md
# Motion Delta Register Bank

This block sits behind a serial register port in a motion sensor and holds the values a host polls to learn how far the sensor has moved. Once per frame the image pipeline presents a strobe with a signed X and Y displacement. The bank adds each displacement into its own 8-bit two's-complement counter, which saturates at its limits. It raises a motion flag whenever a nonzero displacement arrives. The host reads the counters through a simple read/write strobe bus, and reading them consumes them.

Reads and writes have side effects. Reading the X count clears both counters, sets the flag back to zero and parks the Y count in a snapshot. The next read of the Y address returns that snapshot. Writing anything to the status address throws all pending motion away. Writing one key value to the reset address brings every register back to its default, the same as the reset pin.

The bank also decodes a few control registers into levels for the rest of the sensor: a power-down level, the resolution in effect (as a count of 125-cpi steps) and a steady-LED level.

Top module: `motion_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register returns to its default: both counters, the snapshot and the motion flag are 0, address 0x0d holds 0x00, 0x19 holds 0x08 and 0x22 holds 0x00. The outputs then show `pwr_down`=0, `res_steps`=4 and `led_dc`=0.
- R2: A read is requested with `rd_en` high for one cycle. `rdata` shows the value of the addressed register on the following cycle, as it stood before the read's side effects. Any unmapped address reads 0x00. When no read was requested, `rdata` is 0x00.
- R3: The fixed identity addresses read 0x00→0x12, 0x01→0x01, 0x3e→0x26 and 0x3f→0xfe. The last value is the bitwise inverse of the value at 0x01.
- R4: Each `frame_vld` cycle adds the signed `frame_dx` and `frame_dy` into the X and Y counters. The counters saturate at +127 (0x7f) and -128 (0x80) instead of wrapping.
- R5: Address 0x02 reads 0x80 (bit 7 set, all other bits 0) after a frame with nonzero `frame_dx` or `frame_dy`. It reads 0x00 otherwise. A frame with both values zero does not set the flag.
- R6: A read of 0x03 returns the X count. It then clears the X count, clears the flag, copies the Y count into the snapshot and clears the Y count. A read of 0x04 returns the snapshot and clears it.
- R7: A write of any value to 0x02 clears the flag, both counters and the snapshot. The written value is not stored, so 0x02 then reads 0x00.
- R8: A frame that lands in the same cycle as a clearing read of 0x03 or a write to 0x02 is not lost. Its displacement becomes the new count, and a nonzero frame sets the flag.
- R9: A write of 0x5a to 0x3a has the same effect as R1 at the next edge, and a frame in that same cycle is dropped. Any other value written to 0x3a has no effect.
- R10: Address 0x0d stores bits 1:0 and reads back with its other bits 0. Bit 1 drives `pwr_down`. When R11 does not apply, bit 0 selects `res_steps` = 4 (bit 0 = 0) or 8 (bit 0 = 1).
- R11: Address 0x19 stores bits 4:0 and reads back with its other bits 0. When bit 4 is 1 and bits 3:0 hold a code from 1 to 11, `res_steps` equals that code. Otherwise the R10 rule decides.
- R12: Address 0x22 stores a full byte. `led_dc` is 1 when that byte is exactly 0x80 or the motion flag is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_vld | input | 1 | Frame displacement strobe |
| frame_dx | input | 8 | Signed X displacement of the frame |
| frame_dy | input | 8 | Signed Y displacement of the frame |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe (never high together with rd_en) |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| pwr_down | output | 1 | Power-down level |
| res_steps | output | 4 | Resolution in effect, in 125-cpi steps |
| led_dc | output | 1 | 1 = LED steady, 0 = LED pulsed |

## Verification
The bound checker watches several rules on every cycle:
- `rdata` stays zero after a cycle without a read, and the identity value follows a read of 0x00.
- The key write restores the default levels.
- A nonzero frame always lights the steady-LED level, even when a clear lands in the same cycle.
- The power-down level follows the written bit.
- The LED-force value takes hold.
- The resolution step count never leaves the 1 to 11 range.

Some behaviour depends on a history of several bus operations, and only the bench's reference model can show it. This covers saturation after long runs of frames, the Y snapshot surviving until its own read, the write-only status clear leaving nothing stored, and invalid resolution codes falling back to the 0x0d rule.

// File: rtl/mrb_pkg.sv
`timescale 1ns/1ps
// Package: register addresses, fixed identity values and resolution
// constants shared by the motion register bank and its checker.
package mrb_pkg;
    localparam int unsigned A_PID     = 'h00;
    localparam int unsigned A_REV     = 'h01;
    localparam int unsigned A_STAT    = 'h02;
    localparam int unsigned A_DX      = 'h03;
    localparam int unsigned A_DY      = 'h04;
    localparam int unsigned A_MCTL    = 'h0d;
    localparam int unsigned A_RCTL    = 'h19;
    localparam int unsigned A_LED     = 'h22;
    localparam int unsigned A_SRST    = 'h3a;
    localparam int unsigned A_PID2    = 'h3e;
    localparam int unsigned A_IREV    = 'h3f;

    localparam logic [7:0] V_PID      = 8'h12;
    localparam logic [7:0] V_REV      = 8'h01;
    localparam logic [7:0] V_PID2     = 8'h26;
    localparam logic [7:0] V_SRST_KEY = 8'h5a;
    localparam logic [7:0] V_LED_DC   = 8'h80;

    localparam int MCTL_W      = 2;      // stored bits of 0x0d
    localparam int RCTL_W      = 5;      // stored bits of 0x19
    localparam int RES_W       = 4;      // width of the step count
    localparam logic [RCTL_W-1:0] RCTL_DEFAULT = 5'h08;
    localparam int RES_LO_STEPS = 4;     // 500 cpi
    localparam int RES_HI_STEPS = 8;     // 1000 cpi
    localparam int RES_MAX_CODE = 11;    // 1375 cpi
endpackage

// File: rtl/mrb_axis_acc.sv
`timescale 1ns/1ps
// Saturating signed accumulator for one motion axis.
// Assumes: kill (software reset) outranks everything and drops a same-cycle
// frame; clr zeroes the count first, and a same-cycle frame then becomes the
// new count.
module mrb_axis_acc #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kill,
    input  logic                clr,
    input  logic                add_vld,
    input  logic signed [W-1:0] add_val,
    output logic signed [W-1:0] cnt
);
    localparam logic signed [W:0] MAXV = $signed({2'b00, {(W-1){1'b1}}});
    localparam logic signed [W:0] MINV = $signed({2'b11, {(W-1){1'b0}}});

    logic signed [W:0]   base;
    logic signed [W:0]   sum;
    logic signed [W-1:0] sat;

    // Form the widened sum and clamp it to the W-bit signed range.
    always_comb begin
        base = clr ? '0 : {cnt[W-1], cnt};
        sum  = base + {add_val[W-1], add_val};
        if (sum > MAXV)      sat = MAXV[W-1:0];
        else if (sum < MINV) sat = MINV[W-1:0];
        else                 sat = sum[W-1:0];
    end

    // Count register: reset, then accumulate, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n || kill)  cnt <= '0;
        else if (add_vld)    cnt <= sat;
        else if (clr)        cnt <= '0;
    end
endmodule

// File: rtl/mrb_ctrl_regs.sv
`timescale 1ns/1ps
// Control registers: power/resolution, resolution override and LED mode.
// Decodes them into the power-down level, the step count in effect and
// the LED force level. Assumes one bus operation per cycle.
module mrb_ctrl_regs
    import mrb_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [MCTL_W-1:0] mctl,
    output logic [RCTL_W-1:0] rctl,
    output logic [DW-1:0]     ledm,
    output logic              pwr_down,
    output logic [RES_W-1:0]  res_steps,
    output logic              led_force
);
    logic [RES_W-1:0] code;
    logic             code_ok;

    // Register writes, with both reset sources restoring the defaults.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            mctl <= '0;
            rctl <= RCTL_DEFAULT;
            ledm <= '0;
        end else if (wr_en) begin
            if (addr == AW'(A_MCTL)) mctl <= wdata[MCTL_W-1:0];
            if (addr == AW'(A_RCTL)) rctl <= wdata[RCTL_W-1:0];
            if (addr == AW'(A_LED))  ledm <= wdata;
        end
    end

    // Decode the levels; the override applies only when enabled and in range.
    always_comb begin
        code     = rctl[RES_W-1:0];
        code_ok  = rctl[RCTL_W-1] && (code >= RES_W'(1)) && (code <= RES_W'(RES_MAX_CODE));
        if (code_ok)      res_steps = code;
        else if (mctl[0]) res_steps = RES_W'(RES_HI_STEPS);
        else              res_steps = RES_W'(RES_LO_STEPS);
        pwr_down  = mctl[1];
        led_force = (ledm == DW'(V_LED_DC));
    end
endmodule

// File: rtl/motion_regbank.sv
`timescale 1ns/1ps
// Motion delta register bank (top). Accumulates per-frame X/Y displacement,
// keeps the motion flag and the Y snapshot, applies the clear-on-read and
// clear-on-write rules and the software reset key, and registers read data.
// Assumes rd_en and wr_en are never high in the same cycle.
module motion_regbank
    import mrb_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_vld,
    input  logic [DW-1:0] frame_dx,
    input  logic [DW-1:0] frame_dy,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          pwr_down,
    output logic [RES_W-1:0] res_steps,
    output logic          led_dc
);
    localparam int NAX = 2;                 // axes: 0 = X, 1 = Y

    logic                 srst, wipe, rd_x, rd_y, moved;
    logic signed [DW-1:0] cnt   [NAX];
    logic signed [DW-1:0] delta [NAX];
    logic [DW-1:0]        ysnap;
    logic                 mot;
    logic [MCTL_W-1:0]    mctl;
    logic [RCTL_W-1:0]    rctl;
    logic [DW-1:0]        ledm;
    logic                 led_force;
    logic [DW-1:0]        rd_mux;

    // Decode the bus strobes that carry side effects.
    always_comb begin
        srst  = wr_en && (addr == AW'(A_SRST)) && (wdata == DW'(V_SRST_KEY));
        wipe  = wr_en && (addr == AW'(A_STAT));
        rd_x  = rd_en && (addr == AW'(A_DX));
        rd_y  = rd_en && (addr == AW'(A_DY));
        moved = frame_vld && ((frame_dx != '0) || (frame_dy != '0));
        delta[0] = $signed(frame_dx);
        delta[1] = $signed(frame_dy);
    end

    // One saturating counter per axis; a read of X clears both.
    for (genvar g = 0; g < NAX; g++) begin : g_axis
        mrb_axis_acc #(.W(DW)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .kill    (srst),
            .clr     (wipe || rd_x),
            .add_vld (frame_vld),
            .add_val (delta[g]),
            .cnt     (cnt[g])
        );
    end

    mrb_ctrl_regs #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (srst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .mctl      (mctl),
        .rctl      (rctl),
        .ledm      (ledm),
        .pwr_down  (pwr_down),
        .res_steps (res_steps),
        .led_force (led_force)
    );

    // Motion flag: a nonzero frame sets it, and that outranks any clear.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)    mot <= 1'b0;
        else if (moved)        mot <= 1'b1;
        else if (wipe || rd_x) mot <= 1'b0;
    end

    // Y snapshot, taken when X is read and consumed when Y is read.
    always_ff @(posedge clk) begin
        if (!rst_n || srst || wipe) ysnap <= '0;
        else if (rd_x)              ysnap <= cnt[1];
        else if (rd_y)              ysnap <= '0;
    end

    // Read multiplexer over the state as it was before this edge.
    always_comb begin
        case (addr)
            AW'(A_PID):  rd_mux = DW'(V_PID);
            AW'(A_REV):  rd_mux = DW'(V_REV);
            AW'(A_STAT): rd_mux = {mot, {(DW-1){1'b0}}};
            AW'(A_DX):   rd_mux = cnt[0];
            AW'(A_DY):   rd_mux = ysnap;
            AW'(A_MCTL): rd_mux = DW'(mctl);
            AW'(A_RCTL): rd_mux = DW'(rctl);
            AW'(A_LED):  rd_mux = ledm;
            AW'(A_PID2): rd_mux = DW'(V_PID2);
            AW'(A_IREV): rd_mux = ~DW'(V_REV);
            default:     rd_mux = '0;
        endcase
    end

    // Registered read data; zero on cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) rdata <= '0;
        else if (rd_en)     rdata <= rd_mux;
        else                rdata <= '0;
    end

    assign led_dc = led_force || mot;
endmodule

// File: rtl/motion_regbank_chk.sv
`timescale 1ns/1ps
// Checker bound to motion_regbank: per-cycle rules seen at the ports.
module motion_regbank_chk
    import mrb_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_vld,
    input logic [DW-1:0] frame_dx,
    input logic [DW-1:0] frame_dy,
    input logic          rd_en,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          pwr_down,
    input logic [RES_W-1:0] res_steps,
    input logic          led_dc
);
    logic key_wr;
    assign key_wr = wr_en && (addr == AW'(A_SRST)) && (wdata == DW'(V_SRST_KEY));

    // R2: no read last cycle means zero read data
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> (rdata == '0));

    // R3: identity register value
    a_r3_pid_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(A_PID)) |=> (rdata == DW'(V_PID)));

    // R9: key write restores the default levels
    a_r9_key_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (!pwr_down && res_steps == RES_W'(RES_LO_STEPS) && !led_dc));

    // R5 and R8: a nonzero frame always raises the flag, hence the steady LED
    a_r5_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && (frame_dx != '0 || frame_dy != '0) && !key_wr) |=> led_dc);

    // R10: power-down level follows the written bit
    a_r10_pd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_MCTL)) |=> (pwr_down == $past(wdata[1])));

    // R12: force value holds the LED steady
    a_r12_led_force: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(A_LED) && wdata == DW'(V_LED_DC)) |=> led_dc);

    // R11: step count stays within the legal codes
    a_r11_steps_range: assert property (@(posedge clk) disable iff (!rst_n)
        (res_steps >= RES_W'(1)) && (res_steps <= RES_W'(RES_MAX_CODE)));
endmodule

bind motion_regbank motion_regbank_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/motion_regbank_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped on every clock and compared
// against all outputs at each falling edge.
module motion_regbank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_vld = 1'b0;
    logic [7:0] frame_dx = '0, frame_dy = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pwr_down;
    logic [3:0] res_steps;
    logic       led_dc;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // model state
    int mx = 0, my = 0, ys = 0, mot = 0, c0d = 0, c19 = 8, c22 = 0, e_rd = 0;

    always #10 clk = ~clk;   // 50 MHz

    motion_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_dx(frame_dx),
        .frame_dy(frame_dy), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwr_down(pwr_down),
        .res_steps(res_steps), .led_dc(led_dc)
    );

    function automatic int clip(int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int rd_val(int a);
        case (a)
            'h00: return 'h12;
            'h01: return 'h01;
            'h02: return mot ? 'h80 : 0;
            'h03: return mx & 255;
            'h04: return ys & 255;
            'h0d: return c0d;
            'h19: return c19;
            'h22: return c22;
            'h3e: return 'h26;
            'h3f: return 'hfe;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_steps();
        int code = c19 & 15;
        if ((c19 & 16) != 0 && code >= 1 && code <= 11) return code;
        return (c0d & 1) ? 8 : 4;
    endfunction

    task automatic model_tick();
        int omy = my;
        int dx = $signed(frame_dx);
        int dy = $signed(frame_dy);
        if (!rst_n || (wr_en && addr == 7'h3a && wdata == 8'h5a)) begin
            mx = 0; my = 0; ys = 0; mot = 0; c0d = 0; c19 = 8; c22 = 0; e_rd = 0;
        end else begin
            e_rd = rd_en ? rd_val(addr) : 0;
            if (wr_en && addr == 7'h02) begin mx = 0; my = 0; ys = 0; mot = 0; end
            if (rd_en && addr == 7'h03) begin ys = omy; mx = 0; my = 0; mot = 0; end
            if (rd_en && addr == 7'h04) ys = 0;
            if (wr_en && addr == 7'h0d) c0d = wdata & 3;
            if (wr_en && addr == 7'h19) c19 = wdata & 31;
            if (wr_en && addr == 7'h22) c22 = wdata;
            if (frame_vld) begin
                mx = clip(mx + dx);
                my = clip(my + dy);
                if (dx != 0 || dy != 0) mot = 1;
            end
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int er = exp_steps();
        int el = (c22 == 'h80 || mot != 0) ? 1 : 0;
        check(rdata == e_rd[7:0], tag, "rdata", rdata, e_rd & 255);
        check(pwr_down == c0d[1], tag, "pwr_down", pwr_down, c0d[1]);
        check(res_steps == er[3:0], tag, "res_steps", res_steps, er);
        check(led_dc == el[0], tag, "led_dc", led_dc, el);
    endtask

    task automatic cyc(input bit r, input bit w, input int a, input int d,
                       input bit f, input int x, input int y, input string tag);
        rd_en = r; wr_en = w; addr = a[6:0]; wdata = d[7:0];
        frame_vld = f; frame_dx = x[7:0]; frame_dy = y[7:0];
        @(posedge clk);
        model_tick();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic rd(input int a, input string tag);     cyc(1, 0, a, 0, 0, 0, 0, tag); endtask
    task automatic wr(input int a, input int d, input string tag); cyc(0, 1, a, d, 0, 0, 0, tag); endtask
    task automatic fr(input int x, input int y, input string tag); cyc(0, 0, 0, 0, 1, x, y, tag); endtask
    task automatic idle(input string tag);                 cyc(0, 0, 0, 0, 0, 0, 0, tag); endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=done", n_chk);
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        idle("R1"); idle("R1");
        rst_n = 1'b1;
        idle("R1");
        rd('h19, "R1"); rd('h0d, "R1"); rd('h22, "R1"); rd('h02, "R1"); idle("R1");
        // R3 and R2: identity values, unmapped address
        rd('h00, "R3"); rd('h01, "R3"); rd('h3e, "R3"); rd('h3f, "R3");
        rd('h10, "R2"); rd('h3a, "R2"); idle("R2");
        // R4, R5, R6: accumulate then report
        fr(5, -3, "R4"); fr(10, 0, "R4");
        rd('h02, "R5"); rd('h03, "R6"); rd('h04, "R6"); rd('h04, "R6"); rd('h02, "R6");
        // R5: zero frame leaves flag clear
        fr(0, 0, "R5"); rd('h02, "R5");
        // R4: saturation both ways
        for (int i = 0; i < 6; i++) fr(100, -100, "R4");
        rd('h03, "R4"); rd('h04, "R4");
        for (int i = 0; i < 6; i++) fr(-90, 90, "R4");
        rd('h03, "R4"); rd('h04, "R4");
        // R7: status write wipes everything and stores nothing
        fr(7, 9, "R7"); wr('h02, 'hff, "R7");
        rd('h02, "R7"); rd('h03, "R7"); rd('h04, "R7");
        // R8: frame concurrent with clearing read and write
        fr(3, 4, "R8");
        cyc(1, 0, 'h03, 0, 1, 7, -2, "R8");
        rd('h02, "R8"); rd('h03, "R8"); rd('h04, "R8");
        fr(20, 20, "R8");
        cyc(0, 1, 'h02, 'h55, 1, -6, 1, "R8");
        rd('h02, "R8"); rd('h03, "R8"); rd('h04, "R8");
        // R10: power and base resolution
        wr('h0d, 'hff, "R10"); rd('h0d, "R10");
        wr('h0d, 'h01, "R10"); rd('h0d, "R10");
        // R11: resolution override
        wr('h19, 'hf5, "R11"); rd('h19, "R11");
        wr('h19, 'h1c, "R11"); wr('h19, 'h10, "R11"); wr('h19, 'h0b, "R11");
        wr('h19, 'h1b, "R11"); wr('h19, 'h11, "R11");
        // R12: LED mode
        wr('h22, 'h80, "R12"); rd('h22, "R12");
        wr('h22, 'h81, "R12"); rd('h22, "R12");
        fr(1, 0, "R12"); rd('h03, "R12");
        wr('h22, 'h80, "R12");
        // R9: wrong key ignored, right key resets, frame in the same cycle dropped
        fr(11, 12, "R9");
        wr('h3a, 'h5b, "R9"); rd('h0d, "R9"); rd('h22, "R9"); rd('h02, "R9");
        cyc(0, 1, 'h3a, 'h5a, 1, 9, 9, "R9");
        rd('h02, "R9"); rd('h03, "R9"); rd('h19, "R9"); rd('h22, "R9");
        // R1: pin reset mid-run
        wr('h0d, 'h02, "R1"); fr(4, 4, "R1");
        rst_n = 1'b0; idle("R1");
        rst_n = 1'b1; idle("R1");
        rd('h03, "R1"); rd('h0d, "R1"); idle("R1");
        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule